// File: doc/BRIEF.md
# GPIO Input Interrupt Status Bank

This block keeps one sticky interrupt status bit for each pad of a group of general-purpose input pads. Each raw pad input is brought into the clock domain by a two-flop synchronizer. An optional per-pad inversion is applied to the synchronized value. A per-pad two-bit code then selects what counts as an event: a level, a rising edge, a falling edge or either edge. A detected event latches the pad's status bit only when the pad is configured as a GPIO input and is owned by the host driver. Ownership means a three-bit owner field of zero together with a host-software ownership flag of one.

Software reads the status bits through a 32-bit register port and clears them by writing ones. The two highest pad bits cannot be cleared by software. Register bits above the pad range read as zero. A per-pad enable mask is ANDed with the status, and the results are ORed into a single registered interrupt line. The enable mask does not stop status capture. Each pad also chooses one of several synchronous reset domains that can clear its status bit on its own, and the global asynchronous reset clears the whole bank.

Top module: `gpi_int_status_bank`

## Requirements
- R1: After the global reset, every status bit, the read data and the interrupt output are 0.
- R2: With event code 00 (level), a pad's status bit is set on every cycle in which its synchronized, inversion-adjusted input is 1. A raw input change is visible in the read data after the third rising clock edge.
- R3: Event code 01 sets the bit on a 0-to-1 change of the inversion-adjusted synchronized input. Code 10 sets it on a 1-to-0 change, and code 11 sets it on either change. A change of the opposite kind does not set the bit.
- R4: When a pad's inversion bit is 1, event detection works on the complemented input. Toggling the inversion bit while the input is steady creates no edge event.
- R5: A status bit is set only when the pad is in GPIO input mode, its three-bit owner field equals 000 and its host-ownership flag equals 1. Events at any other time are dropped.
- R6: A register write with bit i = 1 clears status bit i of every software-clearable pad (pads 0 to NUM_PADS-NUM_RO-1) at the write's clock edge. A 0 in a bit leaves that bit unchanged.
- R7: When a hardware event and a software clear hit the same bit at the same edge, the bit ends at 1.
- R8: Register bits 31 down to NUM_PADS always read 0, and writes to them are ignored. The top NUM_RO pad bits (24 and 25 by default) ignore software writes but are still set by hardware events.
- R9: The enable mask does not affect status capture. The interrupt output equals the OR over all pads of (status AND enable) as it was one clock earlier.
- R10: A pad whose reset-select field holds k has its status bit cleared at every edge at which domain reset k is 1. This reset wins over a simultaneous event, and pads that select another domain are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global asynchronous reset, active low |
| padIn | input | NUM_PADS | Raw asynchronous pad inputs |
| padIsInput | input | NUM_PADS | 1 = pad configured in GPIO input mode |
| padOwner | input | NUM_PADS*3 | Three-bit owner field per pad, host driver = 000 |
| hostOwn | input | NUM_PADS | Host-software ownership flag per pad |
| rxInvert | input | NUM_PADS | Receive inversion per pad |
| rxEvtCfg | input | NUM_PADS*2 | Event code per pad: 00 level, 01 rise, 10 fall, 11 both |
| padRstSel | input | NUM_PADS*SEL_W | Reset-domain select per pad |
| domainRst | input | NUM_DOM | Synchronous reset request per domain, active high |
| intEnable | input | NUM_PADS | Interrupt enable mask |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data, 1 = clear |
| regRdData | output | 32 | Status register read data |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Two functions can land on the same bit at one clock edge: a hardware event setting the bit and a software write-one clearing it. A per-pad domain reset can also coincide with an event. The bench provokes the first case by timing a write strobe onto the third edge after a pad rises, and by clearing a level-mode pad while its input is still high. In both cases the bit must read 1 afterwards. It provokes the second case by holding a domain reset while a level-mode pad is asserting, and the bit must read 0 at that edge and return once the reset is released.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
  localparam int REG_W = 32;
  localparam int OWN_W = 3;

  typedef enum logic [1:0] {
    EVT_LEVEL = 2'b00,
    EVT_RISE  = 2'b01,
    EVT_FALL  = 2'b10,
    EVT_ANY   = 2'b11
  } rxEvt_e;

  // Strobes from the control decode to the status datapath, one bit per register position.
  typedef struct packed {
    logic [REG_W-1:0] swClr;
    logic [REG_W-1:0] domRst;
  } statusStrobes_t;
endpackage

// File: rtl/gpi_event_path.sv
module gpi_event_path #(
  parameter int NUM_PADS = 26
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PADS-1:0]               padIn,
  input  logic [NUM_PADS-1:0]               padIsInput,
  input  logic [NUM_PADS*gpi_pkg::OWN_W-1:0] padOwner,
  input  logic [NUM_PADS-1:0]               hostOwn,
  input  logic [NUM_PADS-1:0]               rxInvert,
  input  logic [NUM_PADS*2-1:0]             rxEvtCfg,
  output logic [NUM_PADS-1:0]               setReq
);
  localparam int OW = gpi_pkg::OWN_W;

  logic [NUM_PADS-1:0] syncA, syncB, prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    gpi_pkg::rxEvt_e cfgCode;
    logic curV, prvV, hit, qual;

    assign cfgCode = gpi_pkg::rxEvt_e'(rxEvtCfg[2*i +: 2]);
    // The inversion applies to both samples, so flipping it alone creates no edge.
    assign curV = syncB[i] ^ rxInvert[i];
    assign prvV = prevB[i] ^ rxInvert[i];
    assign qual = padIsInput[i] & hostOwn[i] & (padOwner[OW*i +: OW] == '0);

    always_comb begin
      unique case (cfgCode)
        gpi_pkg::EVT_LEVEL: hit = curV;
        gpi_pkg::EVT_RISE:  hit = curV & ~prvV;
        gpi_pkg::EVT_FALL:  hit = ~curV & prvV;
        default:            hit = curV ^ prvV;
      endcase
    end

    assign setReq[i] = hit & qual;
  end
endmodule

// File: rtl/gpi_status_ctrl.sv
module gpi_status_ctrl #(
  parameter int NUM_PADS = 26,
  parameter int NUM_RO   = 2,
  parameter int NUM_DOM  = 2,
  localparam int SEL_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                          regWrEn,
  input  logic [gpi_pkg::REG_W-1:0]     regWrData,
  input  logic [NUM_DOM-1:0]            domainRst,
  input  logic [NUM_PADS*SEL_W-1:0]     padRstSel,
  output gpi_pkg::statusStrobes_t       strobes
);
  localparam int RW = gpi_pkg::REG_W;
  localparam int NUM_CLR = NUM_PADS - NUM_RO;
  localparam logic [RW-1:0] CLR_MASK = RW'((64'd1 << NUM_CLR) - 64'd1);

  logic [RW-1:0] swClrV, domRstV;

  assign swClrV = regWrEn ? (regWrData & CLR_MASK) : '0;

  for (genvar i = 0; i < RW; i++) begin : g_dom
    if (i < NUM_PADS) begin : g_live
      logic [SEL_W-1:0] sel;
      assign sel = padRstSel[i*SEL_W +: SEL_W];
      assign domRstV[i] = domainRst[sel];
    end else begin : g_none
      assign domRstV[i] = 1'b0;
    end
  end

  assign strobes = '{swClr: swClrV, domRst: domRstV};
endmodule

// File: rtl/gpi_status_dp.sv
module gpi_status_dp #(
  parameter int NUM_PADS = 26,
  parameter int NUM_RO   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PADS-1:0]     setReq,
  input  gpi_pkg::statusStrobes_t strobes,
  input  logic [NUM_PADS-1:0]     intEnable,
  output logic [NUM_PADS-1:0]     status,
  output logic                    irqOut
);
  localparam int RW = gpi_pkg::REG_W;
  localparam logic [NUM_PADS-1:0] RO_MASK =
    NUM_PADS'(((64'd1 << NUM_RO) - 64'd1) << (NUM_PADS - NUM_RO));

  logic [NUM_PADS-1:0] clrV, rstV;
  assign clrV = strobes.swClr[NUM_PADS-1:0];
  assign rstV = strobes.domRst[NUM_PADS-1:0];

  if (NUM_PADS < RW) begin : g_hi
    logic unusedHi;
    assign unusedHi = ^{strobes.swClr[RW-1:NUM_PADS], strobes.domRst[RW-1:NUM_PADS]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      irqOut <= 1'b0;
    end else begin
      // Set wins over clear; domain reset wins over both.
      status <= ((status & ~clrV) | setReq) & ~rstV;
      irqOut <= |(status & intEnable);
    end
  end

  // R7: a set and a clear on the same bit leave it at 1
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((setReq & clrV & ~rstV) != '0) |=>
      ((status & $past(setReq & clrV & ~rstV)) == $past(setReq & clrV & ~rstV)));

  // R6: a clear without a set empties the bit
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((clrV & ~setReq & ~rstV) != '0) |=> ((status & $past(clrV & ~setReq & ~rstV)) == '0));

  // R8: read-only pad bits fall only through a domain reset
  p_ro_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(status) & ~status & RO_MASK & ~$past(rstV)) == '0));

  // R9: interrupt follows enabled status one cycle later
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(status & intEnable))));

  // R10: a domain reset leaves its pads clear
  p_domrst_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rstV != '0) |=> ((status & $past(rstV)) == '0));
endmodule

// File: rtl/gpi_int_status_bank.sv
module gpi_int_status_bank #(
  parameter int NUM_PADS = 26,
  parameter int NUM_RO   = 2,
  parameter int NUM_DOM  = 2,
  localparam int SEL_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_PADS-1:0]                padIn,
  input  logic [NUM_PADS-1:0]                padIsInput,
  input  logic [NUM_PADS*gpi_pkg::OWN_W-1:0] padOwner,
  input  logic [NUM_PADS-1:0]                hostOwn,
  input  logic [NUM_PADS-1:0]                rxInvert,
  input  logic [NUM_PADS*2-1:0]              rxEvtCfg,
  input  logic [NUM_PADS*SEL_W-1:0]          padRstSel,
  input  logic [NUM_DOM-1:0]                 domainRst,
  input  logic [NUM_PADS-1:0]                intEnable,
  input  logic                               regWrEn,
  input  logic [gpi_pkg::REG_W-1:0]          regWrData,
  output logic [gpi_pkg::REG_W-1:0]          regRdData,
  output logic                               irqOut
);
  logic [NUM_PADS-1:0]     setReq, status;
  gpi_pkg::statusStrobes_t strobes;

  gpi_event_path #(.NUM_PADS(NUM_PADS)) u_evt (
    .clk(clk), .rstN(rstN), .padIn(padIn), .padIsInput(padIsInput),
    .padOwner(padOwner), .hostOwn(hostOwn), .rxInvert(rxInvert),
    .rxEvtCfg(rxEvtCfg), .setReq(setReq)
  );

  gpi_status_ctrl #(.NUM_PADS(NUM_PADS), .NUM_RO(NUM_RO), .NUM_DOM(NUM_DOM)) u_ctrl (
    .regWrEn(regWrEn), .regWrData(regWrData), .domainRst(domainRst),
    .padRstSel(padRstSel), .strobes(strobes)
  );

  gpi_status_dp #(.NUM_PADS(NUM_PADS), .NUM_RO(NUM_RO)) u_dp (
    .clk(clk), .rstN(rstN), .setReq(setReq), .strobes(strobes),
    .intEnable(intEnable), .status(status), .irqOut(irqOut)
  );

  assign regRdData = gpi_pkg::REG_W'(status);
endmodule

// File: tb/gpi_int_status_bank_bench.sv
module gpi_int_status_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 26;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NP-1:0] padIn = '0, padIsInput = '1, hostOwn = '1, rxInvert = '0, intEnable = '0;
  logic [NP*3-1:0] padOwner = '0;
  logic [NP*2-1:0] rxEvtCfg;
  logic [NP-1:0] padRstSel = '0;
  logic [1:0] domainRst = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  logic irqOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpi_int_status_bank u_gpi_int_status_bank (
    .clk(clk), .rstN(rstN), .padIn(padIn), .padIsInput(padIsInput),
    .padOwner(padOwner), .hostOwn(hostOwn), .rxInvert(rxInvert),
    .rxEvtCfg(rxEvtCfg), .padRstSel(padRstSel), .domainRst(domainRst),
    .intEnable(intEnable), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic stepTo(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    stepTo(4);
  endtask

  task automatic regWrite(logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic setCfg(int p, logic [1:0] c);
    rxEvtCfg[2*p +: 2] = c;
  endtask

  task automatic pulseDom(int k);
    domainRst[k] = 1'b1;
    @(posedge clk); @(negedge clk);
    domainRst = '0;
  endtask

  task automatic t_reset();
    chk("R1 read after reset", regRdData, 32'h0);
    chk("R1 irq after reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_rise();
    padIn[0] = 1'b1;
    stepTo(2);
    chk("R2 latency not before third edge", regRdData, 32'h0);
    stepTo(1);
    chk("R3 rising sets bit0", regRdData, 32'h1);
    chk("R9 no irq while disabled", {31'b0, irqOut}, 32'h0);
    regWrite(32'h0);
    chk("R6 write 0 keeps bit", regRdData, 32'h1);
    regWrite(32'h1);
    chk("R6 write 1 clears bit", regRdData, 32'h0);
    padIn[0] = 1'b0; settle();
    chk("R3 falling ignored in rise mode", regRdData, 32'h0);
  endtask

  task automatic t_fall_any();
    setCfg(1, 2'b10);
    padIn[1] = 1'b1; settle();
    chk("R3 rise ignored in fall mode", regRdData, 32'h0);
    padIn[1] = 1'b0; settle();
    chk("R3 fall sets bit1", regRdData, 32'h2);
    regWrite(32'h2);
    setCfg(2, 2'b11);
    padIn[2] = 1'b1; settle();
    chk("R3 any-edge rise", regRdData, 32'h4);
    regWrite(32'h4);
    padIn[2] = 1'b0; settle();
    chk("R3 any-edge fall", regRdData, 32'h4);
    regWrite(32'h4);
    chk("R3 cleared", regRdData, 32'h0);
  endtask

  task automatic t_level();
    setCfg(3, 2'b00);
    padIn[3] = 1'b1; settle();
    chk("R2 level sets bit3", regRdData, 32'h8);
    regWrite(32'h8);
    chk("R7 level re-asserts over clear", regRdData, 32'h8);
    padIn[3] = 1'b0; settle();
    regWrite(32'h8);
    chk("R2 clear after level drops", regRdData, 32'h0);
  endtask

  task automatic t_invert();
    setCfg(4, 2'b00);
    rxInvert[4] = 1'b1; settle();
    chk("R4 inverted level on low input", regRdData, 32'h10);
    rxInvert[4] = 1'b0; settle();
    regWrite(32'h10);
    rxInvert[5] = 1'b1; settle();
    chk("R4 invert toggle makes no edge", regRdData, 32'h0);
    padIn[5] = 1'b1; settle();
    chk("R4 raw rise is inverted fall", regRdData, 32'h0);
    padIn[5] = 1'b0; settle();
    chk("R4 raw fall is inverted rise", regRdData, 32'h20);
    rxInvert[5] = 1'b0; settle();
    regWrite(32'h20);
    chk("R4 cleanup", regRdData, 32'h0);
  endtask

  task automatic t_qual();
    padIsInput[6] = 1'b0;
    padIn[6] = 1'b1; settle();
    chk("R5 not input mode", regRdData, 32'h0);
    padIn[6] = 1'b0; padIsInput[6] = 1'b1; padOwner[18 +: 3] = 3'b010; settle();
    padIn[6] = 1'b1; settle();
    chk("R5 owner nonzero", regRdData, 32'h0);
    padIn[6] = 1'b0; padOwner[18 +: 3] = 3'b000; hostOwn[6] = 1'b0; settle();
    padIn[6] = 1'b1; settle();
    chk("R5 host flag clear", regRdData, 32'h0);
    padIn[6] = 1'b0; hostOwn[6] = 1'b1; settle();
    padIn[6] = 1'b1; settle();
    chk("R5 qualified sets", regRdData, 32'h40);
    regWrite(32'h40);
    padIn[6] = 1'b0; settle();
  endtask

  task automatic t_collide();
    padIn[7] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = 32'h80;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    chk("R7 set wins same edge", regRdData, 32'h80);
    regWrite(32'h80);
    chk("R7 later clear", regRdData, 32'h0);
    padIn[7] = 1'b0; settle();
  endtask

  task automatic t_readonly();
    padIn[24] = 1'b1; settle();
    chk("R8 RO pad 24 set by hardware", regRdData, 32'h0100_0000);
    regWrite(32'hFFFF_FFFF);
    chk("R8 RO pad 24 ignores clear", regRdData, 32'h0100_0000);
    padIn[25] = 1'b1; settle();
    regWrite(32'hFC00_0000);
    chk("R8 reserved bits read 0", regRdData, 32'h0300_0000);
  endtask

  task automatic t_irq();
    intEnable[8] = 1'b1;
    padIn[8] = 1'b1; stepTo(3);
    chk("R9 status set with enable", regRdData, 32'h0300_0100);
    chk("R9 irq not yet", {31'b0, irqOut}, 32'h0);
    stepTo(1);
    chk("R9 irq one cycle later", {31'b0, irqOut}, 32'h1);
    regWrite(32'h100);
    chk("R9 irq still high on clear edge", {31'b0, irqOut}, 32'h1);
    stepTo(1);
    chk("R9 irq drops", {31'b0, irqOut}, 32'h0);
    intEnable[8] = 1'b0; padIn[8] = 1'b0; settle();
  endtask

  task automatic t_domain();
    padRstSel[24] = 1'b1; padRstSel[25] = 1'b1;
    pulseDom(0);
    chk("R10 other domain leaves RO pads", regRdData, 32'h0300_0000);
    pulseDom(1);
    chk("R10 selected domain clears", regRdData, 32'h0);
    setCfg(3, 2'b00);
    padIn[3] = 1'b1; settle();
    domainRst[0] = 1'b1; stepTo(1);
    chk("R10 reset beats level event", regRdData, 32'h0);
    domainRst = '0; stepTo(1);
    chk("R10 level returns after reset", regRdData, 32'h8);
    padIn[3] = 1'b0; settle();
    regWrite(32'h8);
    chk("R10 cleanup", regRdData, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) rxEvtCfg[2*i +: 2] = 2'b01;
    stepTo(2);
    rstN = 1'b1;
    stepTo(1);
    t_reset();
    t_rise();
    t_fall_any();
    t_level();
    t_invert();
    t_qual();
    t_collide();
    t_readonly();
    t_irq();
    t_domain();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule